// File: doc/BRIEF.md
# Vector Shift-Right Narrowing Unit

This block takes a 128-bit vector of wide lanes and a 6-bit immediate, and produces a 64-bit vector of narrow lanes. Each narrow lane is half as wide as its wide lane. Each wide lane is shifted right logically by an amount decoded from the immediate, and the low half of the shifted value is kept. The same immediate selects both the lane width and the shift amount, through its highest set bit among the upper three bits. The result does not depend on whether the data is signed or unsigned.

The unit is registered. A strobe captures the inputs, and the result appears one clock later with a valid flag. Alongside the data it reports two error conditions: an immediate that belongs to a different operation, and an odd source register index. When either error is reported the output data is forced to zero and the valid flag stays low. The caller handles register file access, condition evaluation and trapping.

Top module: `vec_narrow_shift`

## Requirements
- R1: The upper three immediate bits select the wide lane width. If bit 5 is set the width is 64 (2 lanes). Otherwise, if bit 4 is set the width is 32 (4 lanes). Otherwise, if bit 3 is set the width is 16 (8 lanes).
- R2: The shift amount is the wide lane width minus the unsigned value of the 6-bit immediate. This gives 1 to half the wide lane width, so an immediate of 8, 16 or 32 gives the largest shift and 15, 31 or 63 gives a shift of 1.
- R3: The shift is logical. Zeros enter from the top, no sign bit is copied, and only the low half-width bits of the shifted lane are kept.
- R4: Wide lane e is taken from `srcVec[e*2w +: 2w]` and narrow lane e is written to `dstVec[e*w +: w]`, where w is the narrow lane width.
- R5: If the immediate's bits 5..3 are 000, a capture gives `badEncoding`=1, `outValid`=0 and `dstVec`=0 one cycle later.
- R6: If bit 0 of `srcIdx` is 1, a capture gives `oddSource`=1, `outValid`=0 and `dstVec`=0 one cycle later.
- R7: `outValid` is high exactly in the cycle after a capture that has no error. It is low in every cycle after a clock edge where `inValid` was low.
- R8: While `rstN` is low, `outValid`, `badEncoding`, `oddSource` and `dstVec` are cleared at the clock edge.
- R9: In a cycle where `inValid` is low, `dstVec` keeps its value and both error flags are low, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Capture strobe for the inputs |
| srcVec | input | 128 | Wide-lane source vector |
| imm | input | 6 | Immediate that selects lane width and shift |
| srcIdx | input | 5 | Source register index, must be even |
| outValid | output | 1 | Result valid, one cycle after a good capture |
| dstVec | output | 64 | Narrow-lane result vector |
| badEncoding | output | 1 | Immediate does not belong to this operation |
| oddSource | output | 1 | Source index was odd |

## Verification
The assertions check the cycle-level contract on every cycle. They cover the one-cycle valid timing, forcing the data to zero and raising each error flag after a bad capture, the data holding still while no capture happens, and valid never being high together with an error flag. They cannot check lane arithmetic. Lane width selection, the shift value, zero fill on lanes whose top bit is set, and lane placement are shown only by the bench. The bench compares every output against a per-lane reference under random and directed immediates, including the smallest and largest shift for each lane width.

// File: rtl/vns_pkg.sv
package vns_pkg;
  localparam int IMM_W = 6;
  localparam int SIZE_COUNT = 3;
  localparam int SHAMT_W = 6;

  typedef struct packed {
    logic                  load;
    logic                  zeroOut;
    logic [SIZE_COUNT-1:0] sizeSel;
    logic [SHAMT_W-1:0]    shamt;
  } ctrlStrobes_t;
endpackage

// File: rtl/vns_ctrl.sv
module vns_ctrl
  import vns_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [IMM_W-1:0] imm,
  input  logic [IDX_W-1:0] srcIdx,
  output ctrlStrobes_t     strobes,
  output logic             outValid,
  output logic             badEncoding,
  output logic             oddSource
);
  logic encErr;
  logic oddErr;
  logic [IMM_W:0] wideWidth;
  logic [IMM_W:0] shiftDiff;

  always_comb begin
    encErr = (imm[5:3] == 3'b000);
    oddErr = srcIdx[0];
    if (imm[5]) begin
      strobes.sizeSel = 3'b100;
      wideWidth = 7'd64;
    end else if (imm[4]) begin
      strobes.sizeSel = 3'b010;
      wideWidth = 7'd32;
    end else if (imm[3]) begin
      strobes.sizeSel = 3'b001;
      wideWidth = 7'd16;
    end else begin
      strobes.sizeSel = 3'b000;
      wideWidth = 7'd16;
    end
    shiftDiff = wideWidth - {1'b0, imm};
    strobes.shamt = shiftDiff[SHAMT_W-1:0];
    strobes.load = inValid;
    strobes.zeroOut = encErr | oddErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      badEncoding <= 1'b0;
      oddSource   <= 1'b0;
    end else begin
      outValid    <= inValid & ~encErr & ~oddErr;
      badEncoding <= inValid & encErr;
      oddSource   <= inValid & oddErr;
    end
  end
endmodule

// File: rtl/vns_datapath.sv
module vns_datapath
  import vns_pkg::*;
#(
  parameter int SRC_W = 128,
  parameter int DST_W = SRC_W / 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [SRC_W-1:0] srcVec,
  output logic [DST_W-1:0] dstVec
);
  logic [DST_W-1:0] narrowed [SIZE_COUNT];
  logic [DST_W-1:0] picked;

  for (genvar k = 0; k < SIZE_COUNT; k++) begin : g_size
    localparam int NW = 8 << k;
    localparam int LANES = DST_W / NW;
    for (genvar e = 0; e < LANES; e++) begin : g_lane
      logic [2*NW-1:0] wideLane;
      logic [2*NW-1:0] shifted;
      assign wideLane = srcVec[e*2*NW +: 2*NW];
      assign shifted = wideLane >> strobes.shamt;
      assign narrowed[k][e*NW +: NW] = shifted[NW-1:0];
    end
  end

  always_comb begin
    picked = '0;
    for (int k = 0; k < SIZE_COUNT; k++) begin
      if (strobes.sizeSel[k]) picked = narrowed[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) dstVec <= '0;
    else if (strobes.load) dstVec <= strobes.zeroOut ? '0 : picked;
  end
endmodule

// File: rtl/vec_narrow_shift.sv
module vec_narrow_shift
  import vns_pkg::*;
#(
  parameter int SRC_W = 128,
  parameter int IDX_W = 5,
  localparam int DST_W = SRC_W / 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SRC_W-1:0] srcVec,
  input  logic [IMM_W-1:0] imm,
  input  logic [IDX_W-1:0] srcIdx,
  output logic             outValid,
  output logic [DST_W-1:0] dstVec,
  output logic             badEncoding,
  output logic             oddSource
);
  ctrlStrobes_t strobes;

  vns_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .imm(imm), .srcIdx(srcIdx),
    .strobes(strobes), .outValid(outValid), .badEncoding(badEncoding),
    .oddSource(oddSource)
  );

  vns_datapath #(.SRC_W(SRC_W), .DST_W(DST_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcVec(srcVec), .dstVec(dstVec)
  );
endmodule

// File: rtl/vec_narrow_shift_chk.sv
module vec_narrow_shift_chk #(
  parameter int SRC_W = 128,
  parameter int IDX_W = 5,
  localparam int DST_W = SRC_W / 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [SRC_W-1:0] srcVec,
  input logic [5:0]       imm,
  input logic [IDX_W-1:0] srcIdx,
  input logic             outValid,
  input logic [DST_W-1:0] dstVec,
  input logic             badEncoding,
  input logic             oddSource
);
  a_r7_valid_after_good: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && imm[5:3] != 3'b000 && !srcIdx[0]) |=> outValid);
  a_r7_no_valid_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r5_bad_encoding: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && imm[5:3] == 3'b000) |=> (badEncoding && !outValid && dstVec == '0));
  a_r6_odd_source: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && srcIdx[0]) |=> (oddSource && !outValid && dstVec == '0));
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && $past(rstN)) |=> ($stable(dstVec) && !badEncoding && !oddSource));
  a_r7_valid_excludes_errors: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (!badEncoding && !oddSource));
endmodule

bind vec_narrow_shift vec_narrow_shift_chk #(.SRC_W(SRC_W), .IDX_W(IDX_W)) chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .srcVec(srcVec), .imm(imm),
  .srcIdx(srcIdx), .outValid(outValid), .dstVec(dstVec),
  .badEncoding(badEncoding), .oddSource(oddSource)
);

// File: tb/vec_narrow_shift_test.sv
module vec_narrow_shift_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [127:0] srcVec = '0;
  logic [5:0] imm = 6'd8;
  logic [4:0] srcIdx = '0;
  logic outValid;
  logic [63:0] dstVec;
  logic badEncoding;
  logic oddSource;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  vec_narrow_shift uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcVec(srcVec), .imm(imm),
    .srcIdx(srcIdx), .outValid(outValid), .dstVec(dstVec),
    .badEncoding(badEncoding), .oddSource(oddSource)
  );

  always #4 clk = ~clk;

  function automatic logic [63:0] refNarrow(input logic [127:0] src, input logic [5:0] im);
    int nw;
    int sh;
    logic [127:0] lane;
    logic [63:0] res;
    nw = im[5] ? 32 : (im[4] ? 16 : 8);
    sh = 2 * nw - int'(im);
    res = '0;
    for (int e = 0; e < 64 / nw; e++) begin
      lane = (src >> (e * 2 * nw)) & ((128'd1 << (2 * nw)) - 128'd1);
      lane = lane >> sh;
      for (int b = 0; b < nw; b++) res[e * nw + b] = lane[b];
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [127:0] s, input logic [5:0] im, input logic [4:0] idx,
                       input string req);
    logic enc;
    logic odd;
    logic [63:0] prev;
    @(negedge clk);
    inValid = 1'b1; srcVec = s; imm = im; srcIdx = idx;
    @(negedge clk);
    inValid = 1'b0;
    enc = (im[5:3] == 3'b000);
    odd = idx[0];
    check({req, " R7 outValid"}, {63'd0, outValid}, {63'd0, !enc && !odd});
    check({req, " R5 badEncoding"}, {63'd0, badEncoding}, {63'd0, enc});
    check({req, " R6 oddSource"}, {63'd0, oddSource}, {63'd0, odd});
    check({req, " R3 R4 dstVec"}, dstVec, (enc || odd) ? 64'd0 : refNarrow(s, im));
    prev = dstVec;
    srcVec = {$urandom, $urandom, $urandom, $urandom};
    imm = 6'($urandom); srcIdx = 5'($urandom);
    @(negedge clk);
    check("R9 hold dstVec", dstVec, prev);
    check("R9 R7 idle flags", {61'd0, outValid, badEncoding, oddSource}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R8 reset outputs", {outValid, badEncoding, oddSource, 61'd0}, 64'd0);
    check("R8 reset dstVec", dstVec, 64'd0);
    rstN = 1'b1;
    // R1 R2 min/max shifts per lane width, with all-ones data for R3
    runOp({128{1'b1}}, 6'd8,  5'd0, "R1 R2 w16 max");
    runOp({128{1'b1}}, 6'd15, 5'd2, "R1 R2 w16 min");
    runOp({128{1'b1}}, 6'd16, 5'd4, "R1 R2 w32 max");
    runOp({128{1'b1}}, 6'd31, 5'd6, "R1 R2 w32 min");
    runOp({128{1'b1}}, 6'd32, 5'd8, "R1 R2 w64 max");
    runOp({128{1'b1}}, 6'd63, 5'd10, "R1 R2 w64 min");
    runOp({8{16'h8001}}, 6'd15, 5'd0, "R3 sign bit w16");
    runOp(128'h0123456789abcdef_fedcba9876543210, 6'd20, 5'd0, "R4 lanes w32");
    runOp({128{1'b1}}, 6'd5, 5'd0, "R5 bad encoding");
    runOp({128{1'b1}}, 6'd40, 5'd3, "R6 odd source");
    runOp({128{1'b1}}, 6'd0, 5'd1, "R5 R6 both");
    for (int i = 0; i < 400; i++) begin
      logic [5:0] im;
      logic [4:0] idx;
      im = 6'($urandom);
      if (($urandom % 8) != 0 && im[5:3] == 3'b000) im[3] = 1'b1;
      idx = 5'($urandom);
      if (($urandom % 6) != 0) idx[0] = 1'b0;
      runOp({$urandom, $urandom, $urandom, $urandom}, im, idx, "R1 R2 random");
    end
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R8 mid-run reset", {outValid, badEncoding, oddSource, dstVec}, 67'd0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule